// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter

This block holds two timer/counter channels. Each channel has a low and a high 8-bit count register. One shared 8-bit configuration byte sets how both channels work. A channel advances either once per machine cycle, which is a fixed number of CPU clocks (six by default), or once per falling edge seen on its external count pin. Counting can be gated: the channel's run bit must be set and, when gating is enabled for that channel, its gate pin must also be high.

Each channel has four modes:
- a 13-bit counter, where the low register supplies a 5-bit prescaler below the high register;
- a 16-bit cascade of the two registers;
- an 8-bit counter in the low register that reloads from the high register when it overflows;
- a split mode, valid for channel 0 only, in which channel 0 becomes two independent 8-bit timers and the upper one borrows channel 1's run bit.

Each channel has a sticky overflow flag and an optional toggle output that flips on every overflow. Software reaches all state through a simple register port: a synchronous write and a combinational read.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 00h, and `ovf_o` and `tog_o` are 0. The address map is: 0 configuration, 1 control, 2 low count 0, 3 high count 0, 4 low count 1, 5 high count 1. Any other address reads 00h.
- R2: When a channel's source bit is 0 (timer function), the count advances by exactly one for every 6 clock cycles in which the channel is enabled.
- R3: When a channel's source bit is 1 (counter function), its pin is sampled once per machine cycle. A high sample followed by a low sample adds one to the count. The increment appears one machine cycle after the low sample is taken.
- R4: The configuration byte gives channel 0 bits [3:0] and channel 1 bits [7:4]. Within each nibble, bits [1:0] are the mode, bit 2 is the source (1 = external pin), and bit 3 is the gate enable. With the gate enable set, the channel counts only while its control run bit is 1 and its `gate_pin_i` bit is high.
- R5: Mode 0 (13-bit) increments the low register's bits [4:0] and carries into the high register. Low bits [7:5] are left unchanged. The overflow runs from FFh:1Fh to 00h:00h.
- R6: Mode 1 (16-bit) counts {high, low}. Overflow occurs when the pair rolls from FFFFh to 0000h.
- R7: Mode 2 counts in the low register. When the low register would pass FFh, it loads the high register's value and an overflow occurs.
- R8: In mode 3, channel 0's low register counts under channel 0's own controls and sets flag 0. Channel 0's high register counts machine cycles whenever control run bit 1 is set, and its overflow sets flag 1. Channel 1 in mode 3 holds its count.
- R9: Overflow flags sit in control bits 4 (channel 0) and 5 (channel 1) and drive `ovf_o`. A flag is set on overflow and stays set. A control write with that bit at 0 clears it; writing 1 leaves it unchanged.
- R10: Control bits 2 and 3 enable the toggle for channels 0 and 1. With the enable set, `tog_o` flips on every event that sets the channel's flag. Control bits 0 and 1 are the run bits.
- R11: A write to a count register takes priority over any increment in the same cycle. In modes 0 to 2, a write to either register of a channel cancels that channel's increment for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | Gate pins, one per channel |
| ovf_o | output | 2 | Sticky overflow flags |
| tog_o | output | 2 | Overflow toggle outputs |

## Verification
Writes take effect at the next clock edge. In timer function, a run window opened and closed by control writes exactly 6n edges apart contains exactly n machine-cycle ticks, whatever the prescaler phase, so the expected counts are exact. In counter function, each pin level is held for one full machine cycle so that it is sampled exactly once. The bench reads the count 6 clocks after a falling level to confirm that nothing has changed yet, and again 6 clocks later to confirm the increment. Reads are combinational and are sampled 1 ns after a falling clock edge, with no clock edge between the stimulus and the read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int W = 8;
  typedef enum logic [1:0] {
    M_13B    = 2'd0,
    M_16B    = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmr_mode_e;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_TL0  = 3'd2;
  localparam logic [2:0] A_TH0  = 3'd3;
  localparam logic [2:0] A_TL1  = 3'd4;
  localparam logic [2:0] A_TH1  = 3'd5;
endpackage

// File: rtl/tmr_mcycle.sv
module tmr_mcycle #(
  parameter int DIV = 6,
  parameter int N   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic         tick_o,
  output logic [N-1:0] fall_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [N-1:0]  samp_q, evt_q;

  assign tick_o = (pre_q == PW'(DIV - 1));
  assign fall_o = {N{tick_o}} & evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      samp_q <= '0;
      evt_q  <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) begin
        samp_q <= pin_i;
        evt_q  <= samp_q & ~pin_i; // acted on at the next tick
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    p_evt_low_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q[k] |-> !samp_q[k]);
  end
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int PS_W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         step_lo_i,
  input  logic         step_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] tl_o,
  output logic [W-1:0] th_o,
  output logic         ovf_lo_o,
  output logic         ovf_hi_o
);
  logic [W-1:0] tl_q, th_q, tl_d, th_d;
  logic lo_go, hi_go;

  assign lo_go = step_lo_i & ~wr_lo_i & ((mode_i == M_SPLIT) | ~wr_hi_i);
  assign hi_go = step_hi_i & ~wr_hi_i & (mode_i == M_SPLIT);

  always_comb begin
    tl_d     = tl_q;
    th_d     = th_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    case (mode_i)
      M_13B: if (lo_go) begin
        if (&tl_q[PS_W-1:0]) begin
          tl_d[PS_W-1:0] = '0;
          th_d           = th_q + 1'b1;
          ovf_lo_o       = &th_q;
        end else begin
          tl_d[PS_W-1:0] = tl_q[PS_W-1:0] + 1'b1;
        end
      end
      M_16B: if (lo_go) begin
        {th_d, tl_d} = {th_q, tl_q} + 1'b1;
        ovf_lo_o     = &{th_q, tl_q};
      end
      M_RELOAD: if (lo_go) begin
        if (&tl_q) begin
          tl_d     = th_q;
          ovf_lo_o = 1'b1;
        end else begin
          tl_d = tl_q + 1'b1;
        end
      end
      default: begin
        if (lo_go) begin
          tl_d     = tl_q + 1'b1;
          ovf_lo_o = &tl_q;
        end
        if (hi_go) begin
          th_d     = th_q + 1'b1;
          ovf_hi_o = &th_q;
        end
      end
    endcase
    if (wr_lo_i) tl_d = wr_data_i;
    if (wr_hi_i) th_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0;
      th_q <= '0;
    end else begin
      tl_q <= tl_d;
      th_q <= th_d;
    end
  end

  assign tl_o = tl_q;
  assign th_o = th_q;

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> tl_q == $past(wr_data_i));
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_lo_o && mode_i == M_RELOAD) |=> tl_q == $past(th_q));
  p_wrap16_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_lo_o && mode_i == M_16B) |=> {th_q, tl_q} == '0);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int MC_DIV = 6,
  parameter int PS_W   = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [2:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  input  logic [1:0]   cnt_pin_i,
  input  logic [1:0]   gate_pin_i,
  output logic [1:0]   ovf_o,
  output logic [1:0]   tog_o
);
  localparam int NCH = 2;

  logic [W-1:0]     mode_q;
  logic [NCH-1:0]   run_q, ten_q, flag_q, tog_q;
  logic             tick, wr_ctrl;
  logic [NCH-1:0]   fall, step_lo, step_hi, ovf_lo, ovf_hi, set_ev;
  logic [W-1:0]     tl [NCH];
  logic [W-1:0]     th [NCH];

  assign wr_ctrl = wr_en_i & (wr_addr_i == A_CTRL);

  tmr_mcycle #(.DIV(MC_DIV), .N(NCH)) u_mcycle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cnt_pin_i),
    .tick_o(tick),
    .fall_o(fall)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tmr_mode_e mode;
    logic      ct, gate, en;
    assign mode = tmr_mode_e'(mode_q[4*k +: 2]);
    assign ct   = mode_q[4*k + 2];
    assign gate = mode_q[4*k + 3];
    assign en   = run_q[k] & (~gate | gate_pin_i[k]);
    if (k == 0) begin : g_lead
      assign step_lo[k] = en & (ct ? fall[k] : tick);
      assign step_hi[k] = run_q[1] & tick;
    end else begin : g_follow
      assign step_lo[k] = en & (ct ? fall[k] : tick) & (mode != M_SPLIT);
      assign step_hi[k] = 1'b0;
    end

    tmr_chan #(.PS_W(PS_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .step_lo_i(step_lo[k]),
      .step_hi_i(step_hi[k]),
      .wr_lo_i  (wr_en_i && wr_addr_i == 3'(A_TL0 + 2*k)),
      .wr_hi_i  (wr_en_i && wr_addr_i == 3'(A_TH0 + 2*k)),
      .wr_data_i(wr_data_i),
      .tl_o     (tl[k]),
      .th_o     (th[k]),
      .ovf_lo_o (ovf_lo[k]),
      .ovf_hi_o (ovf_hi[k])
    );

    p_gate_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate && !gate_pin_i[k]) |-> !step_lo[k]);
    p_timer_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_lo[k] && !ct) |=> !step_lo[k]);
    p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !(wr_ctrl && !wr_data_i[4+k])) |=> flag_q[k]);
    p_toggle_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tog_q[k] != $past(tog_q[k])) |-> $past(set_ev[k] && ten_q[k]));
  end

  // split mode: upper half of channel 0 reports through flag 1
  assign set_ev[0] = ovf_lo[0];
  assign set_ev[1] = ovf_lo[1] | ovf_hi[1] | ((mode_q[1:0] == M_SPLIT) & ovf_hi[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      ten_q  <= '0;
      flag_q <= '0;
      tog_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_MODE) mode_q <= wr_data_i;
      if (wr_ctrl) begin
        run_q <= wr_data_i[1:0];
        ten_q <= wr_data_i[3:2];
      end
      flag_q <= set_ev | (flag_q & ~({NCH{wr_ctrl}} & ~wr_data_i[5:4]));
      tog_q  <= tog_q ^ (set_ev & ten_q);
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_MODE:  rd_data_o = mode_q;
      A_CTRL:  rd_data_o = {2'b00, flag_q, ten_q, run_q};
      A_TL0:   rd_data_o = tl[0];
      A_TH0:   rd_data_o = th[0];
      A_TL1:   rd_data_o = tl[1];
      A_TH1:   rd_data_o = th[1];
      default: rd_data_o = '0;
    endcase
  end

  assign ovf_o = flag_q;
  assign tog_o = tog_q;

  p_t1_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[5:4] == M_SPLIT && !(wr_en_i && (wr_addr_i == A_TL1 || wr_addr_i == A_TH1)))
      |=> ($stable(tl[1]) && $stable(th[1])));
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf, tog;

  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin), .ovf_o(ovf), .tog_o(tog)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // enable for exactly n machine cycles; flags kept, enables kept
  task automatic run_mc(input logic [3:0] ctl, input int n);
    wr(3'd1, {4'b0011, ctl});
    repeat (6 * n - 2) @(negedge clk);
    wr(3'd1, {4'b0011, ctl[3:2], 2'b00});
  endtask

  task automatic clr_flags;
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 8; a++) rdchk("R1 reset read", 3'(a), 8'h00);
    chk("R1 ovf reset", {6'd0, ovf}, 8'h00);
    chk("R1 tog reset", {6'd0, tog}, 8'h00);

    // R2 timer function, mode 1
    wr(3'd0, 8'h01);
    run_mc(4'b0001, 10);
    rdchk("R2 ten cycles", 3'd2, 8'd10);
    repeat (20) @(negedge clk);
    rdchk("R2 holds when stopped", 3'd2, 8'd10);
    wr(3'd0, 8'h11);
    run_mc(4'b0011, 7);
    rdchk("R2 ch0 seven more", 3'd2, 8'd17);
    rdchk("R2 ch1 seven", 3'd4, 8'd7);

    // R4 gating
    wr(3'd0, 8'h09);
    wr(3'd2, 8'h00);
    gate_pin = 2'b00;
    run_mc(4'b0001, 5);
    rdchk("R4 gate low blocks", 3'd2, 8'd0);
    gate_pin = 2'b01;
    run_mc(4'b0001, 5);
    rdchk("R4 gate high counts", 3'd2, 8'd5);
    gate_pin = 2'b00;

    // R5 mode 0
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h1F); wr(3'd3, 8'h05);
    run_mc(4'b0001, 1);
    rdchk("R5 carry low", 3'd2, 8'h00);
    rdchk("R5 carry high", 3'd3, 8'h06);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_mc(4'b0001, 1);
    rdchk("R5 prescale step", 3'd2, 8'hFF);
    chk("R5 no early ovf", {6'd0, ovf}, 8'h00);
    run_mc(4'b0001, 1);
    rdchk("R5 wrap low keeps upper bits", 3'd2, 8'hE0);
    rdchk("R5 wrap high", 3'd3, 8'h00);
    chk("R5 ovf set", {6'd0, ovf}, 8'h01);

    // R9 sticky flag and clear
    repeat (30) @(negedge clk);
    rdchk("R9 flag sticky", 3'd1, 8'h10);
    wr(3'd1, 8'h20);
    rdchk("R9 flag cleared", 3'd1, 8'h00);
    chk("R9 ovf port cleared", {6'd0, ovf}, 8'h00);

    // R6 mode 1 wrap
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_mc(4'b0001, 3);
    rdchk("R6 low", 3'd2, 8'h01);
    rdchk("R6 high", 3'd3, 8'h00);
    chk("R6 ovf", {6'd0, ovf}, 8'h01);
    clr_flags();

    // R7 mode 2 reload
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    run_mc(4'b0001, 3);
    rdchk("R7 reloaded and counted", 3'd2, 8'h81);
    rdchk("R7 reload source kept", 3'd3, 8'h80);
    chk("R7 ovf", {6'd0, ovf}, 8'h01);
    clr_flags();

    // R10 toggle
    wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
    run_mc(4'b0101, 3);
    chk("R10 three toggles", {6'd0, tog}, 8'h01);
    run_mc(4'b0101, 1);
    chk("R10 fourth toggle", {6'd0, tog}, 8'h00);
    clr_flags();

    // R8 split mode
    wr(3'd0, 8'h33);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h55); wr(3'd5, 8'h66);
    run_mc(4'b0011, 2);
    rdchk("R8 low half", 3'd2, 8'h00);
    rdchk("R8 high half", 3'd3, 8'h01);
    rdchk("R8 both flags", 3'd1, 8'h30);
    rdchk("R8 ch1 low held", 3'd4, 8'h55);
    rdchk("R8 ch1 high held", 3'd5, 8'h66);
    run_mc(4'b0010, 3);
    rdchk("R8 high half on run1", 3'd3, 8'h04);
    rdchk("R8 low half idle", 3'd2, 8'h00);
    clr_flags();

    // R3 counter function, mode 1
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin = 2'b11;
    wr(3'd1, 8'h31);
    repeat (12) @(negedge clk);
    cnt_pin[0] = 1'b0;
    repeat (6) @(negedge clk);
    rdchk("R3 not yet visible", 3'd2, 8'd0);
    repeat (6) @(negedge clk);
    rdchk("R3 visible next cycle", 3'd2, 8'd1);
    repeat (12) @(negedge clk);
    rdchk("R3 steady low no count", 3'd2, 8'd1);
    for (int i = 0; i < 4; i++) begin
      cnt_pin[0] = 1'b1;
      repeat (6) @(negedge clk);
      cnt_pin[0] = 1'b0;
      repeat (6) @(negedge clk);
    end
    cnt_pin[0] = 1'b1;
    repeat (18) @(negedge clk);
    wr(3'd1, 8'h30);
    rdchk("R3 five edges", 3'd2, 8'd5);

    // R11 write priority
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    wr(3'd1, 8'h31);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hFF;
    repeat (6) @(negedge clk);
    wr_en = 1'b0;
    rdchk("R11 low written", 3'd2, 8'hFF);
    rdchk("R11 no carry", 3'd3, 8'h00);
    chk("R11 no ovf", {6'd0, ovf}, 8'h00);
    wr(3'd1, 8'h30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule